// File: doc/BRIEF.md
# Decimal 8:2 Carry-Save Compressor

This block takes eight unsigned multi-digit decimal numbers, each digit in the 4-2-2-1 weighted code, and reduces them to two numbers: a sum vector and a doubled-carry vector. The two vectors together equal the total of the eight inputs. No carry travels along the digit string except the one-digit step that each doubling makes. A multiplier uses the block to reduce its partial-product rows. A later stage adds the two vectors with a full carry-propagating decimal adder.

The datapath has three parts. Each of the four bit positions inside a digit gets its own binary 8-to-4 counter. Three-input bitwise carry-save adders merge the counter outputs. Decimal doubling stages turn each weight-2 and weight-4 term back into an ordinary 4-2-2-1 vector. Each doubling recodes every digit into 5-2-1-1 form and shifts the whole vector left by one bit. Both results are captured in one output register, so the block fits a single pipeline stage.

Top module: `dec_csa82`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and both `sum_o` and `dcar_o` are all zeros.
- R2: Every digit is a 4-bit field in which bit 3 weighs 4, bits 2 and 1 weigh 2 each and bit 0 weighs 1. Digit 0 sits in bits 3:0 and higher digits follow upward. All 16 bit patterns are legal digits.
- R3: For every cycle with `in_valid` high, the decoded value of `sum_o` plus the decoded value of `dcar_o` in the next cycle equals the sum of the decoded values of the eight rows.
- R4: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high, and low after a cycle with `in_valid` low.
- R5: In a cycle with `in_valid` low, the row inputs have no effect: `sum_o` and `dcar_o` keep their previous values.
- R6: The outputs are DIGITS+2 digits wide. Eight rows that are all nines (every bit 1) give the exact total 8 × (10^DIGITS − 1).
- R7: `dcar_o` always holds an even value. Its bit 0 (the weight-1 bit of digit 0) is 0 whenever `out_valid` is high.
- R8: Valid inputs on consecutive cycles produce valid results on consecutive cycles, each with its own correct total.
- R9: Eight all-zero rows give `sum_o` and `dcar_o` with every bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Rows are valid this cycle |
| row_i | input | 8 × 4·DIGITS | Eight input numbers, 4-2-2-1 coded |
| out_valid | output | 1 | Result registers hold a fresh result |
| sum_o | output | 4·(DIGITS+2) | Sum vector, 4-2-2-1 coded |
| dcar_o | output | 4·(DIGITS+2) | Doubled-carry vector, 4-2-2-1 coded |

## Verification
Random digit patterns exercise every code point, including the redundant codes for the same value. A wrong weight in the counters or a wrong doubling recode therefore shows up as a wrong total.

Directed rows cover several cases:
- All nines stress the widest output digits.
- All zeros expose any constant injected into the result.
- A single weight-2 pattern placed in bit 2 against one in bit 1 shows whether the two middle bits are treated alike.

Idle cycles carry random data on the rows, which separates a register that loads only on valid cycles from one that loads every cycle. Long back-to-back valid runs show whether one result bleeds into the next.

// File: rtl/dec4221_pkg.sv
package dec4221_pkg;

    // value 0..9 of one 4-2-2-1 coded digit
    function automatic logic [3:0] digit_val(input logic [3:0] d);
        return ({1'b0, d[3], 2'b00} + {2'b00, d[2], 1'b0}
              + {2'b00, d[1], 1'b0} + {3'b000, d[0]});
    endfunction

    // weight-5 bit of the 5-2-1-1 form of a digit
    function automatic logic five_bit(input logic [3:0] d);
        return digit_val(d) >= 4'd5;
    endfunction

    // weight 2,1,1 bits of the 5-2-1-1 form of a digit
    function automatic logic [2:0] low_bits(input logic [3:0] d);
        logic [3:0] r;
        logic [2:0] c;
        r = digit_val(d);
        if (r >= 4'd5) r = r - 4'd5;
        unique case (r)
            4'd0:    c = 3'b000;
            4'd1:    c = 3'b001;
            4'd2:    c = 3'b100;
            4'd3:    c = 3'b101;
            default: c = 3'b111;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bin_cnt84.sv
module bin_cnt84 #(
    parameter int W = 4
) (
    input  logic [7:0][W-1:0] a,
    output logic [W-1:0]      o1,
    output logic [W-1:0]      t2,
    output logic [W-1:0]      k2,
    output logic [W-1:0]      u4
);
    logic [W-1:0] s1, c1, s2, c2, s3, c3;

    // three full adders on the weight-1 level, one half adder to close it
    assign s1 = a[0] ^ a[1] ^ a[2];
    assign c1 = (a[0] & a[1]) | (a[0] & a[2]) | (a[1] & a[2]);
    assign s2 = a[3] ^ a[4] ^ a[5];
    assign c2 = (a[3] & a[4]) | (a[3] & a[5]) | (a[4] & a[5]);
    assign s3 = s1 ^ s2 ^ a[6];
    assign c3 = (s1 & s2) | (s1 & a[6]) | (s2 & a[6]);
    assign o1 = s3 ^ a[7];
    assign k2 = s3 & a[7];
    // fourth full adder folds three weight-2 carries
    assign t2 = c1 ^ c2 ^ c3;
    assign u4 = (c1 & c2) | (c1 & c3) | (c2 & c3);
endmodule

// File: rtl/bin_csa32.sv
module bin_csa32 #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic [W-1:0] z,
    output logic [W-1:0] s,
    output logic [W-1:0] c
);
    assign s = x ^ y ^ z;
    assign c = (x & y) | (x & z) | (y & z);
endmodule

// File: rtl/dec_dbl.sv
module dec_dbl
    import dec4221_pkg::*;
#(
    parameter int DIG = 6
) (
    input  logic [4*DIG-1:0] d,
    output logic [4*DIG-1:0] q
);
    for (genvar i = 0; i < DIG; i++) begin : g_dig
        logic [2:0] lo;
        assign lo = low_bits(d[4*i +: 4]);
        assign q[4*i+3 -: 3] = lo;
        if (i == 0) begin : g_first
            assign q[0] = 1'b0;
        end else begin : g_next
            // weight-5 bit of the lower digit becomes weight 10 here
            assign q[4*i] = five_bit(d[4*(i-1) +: 4]);
        end
    end
endmodule

// File: rtl/dec_csa82.sv
module dec_csa82 #(
    parameter  int DIGITS  = 4,
    localparam int NROWS   = 8,
    localparam int IN_W    = 4 * DIGITS,
    localparam int OUT_DIG = DIGITS + 2,
    localparam int OUT_W   = 4 * OUT_DIG
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    input  logic [NROWS-1:0][IN_W-1:0]  row_i,
    output logic                        out_valid,
    output logic [OUT_W-1:0]            sum_o,
    output logic [OUT_W-1:0]            dcar_o
);
    logic [NROWS-1:0][OUT_W-1:0]            rows_x;
    logic [3:0][NROWS-1:0][OUT_DIG-1:0]     col_in;
    logic [3:0][OUT_DIG-1:0]                col_o, col_t, col_k, col_u;
    logic [OUT_W-1:0] v_o, v_t, v_k, v_u;
    logic [OUT_W-1:0] u_x2, sa, ca, ca_x2, ca_x4, sa_x2, sb, cb, cb_x2;

    for (genvar r = 0; r < NROWS; r++) begin : g_ext
        assign rows_x[r] = {{(OUT_W-IN_W){1'b0}}, row_i[r]};
    end

    // one counter per bit position inside a digit
    for (genvar j = 0; j < 4; j++) begin : g_col
        for (genvar r = 0; r < NROWS; r++) begin : g_row
            for (genvar dg = 0; dg < OUT_DIG; dg++) begin : g_gat
                assign col_in[j][r][dg] = rows_x[r][4*dg+j];
            end
        end
        bin_cnt84 #(.W(OUT_DIG)) u_cnt (
            .a(col_in[j]), .o1(col_o[j]), .t2(col_t[j]),
            .k2(col_k[j]), .u4(col_u[j])
        );
        for (genvar dg = 0; dg < OUT_DIG; dg++) begin : g_sca
            assign v_o[4*dg+j] = col_o[j][dg];
            assign v_t[4*dg+j] = col_t[j][dg];
            assign v_k[4*dg+j] = col_k[j][dg];
            assign v_u[4*dg+j] = col_u[j][dg];
        end
    end

    // total = o + 2t + 2k + 4u = o + 2(t + k + 2u)
    dec_dbl #(.DIG(OUT_DIG)) u_dbl_u (.d(v_u), .q(u_x2));
    bin_csa32 #(.W(OUT_W)) u_csa_a (.x(v_t), .y(v_k), .z(u_x2), .s(sa), .c(ca));
    // total = o + 2*sa + 4*ca
    dec_dbl #(.DIG(OUT_DIG)) u_dbl_s  (.d(sa),    .q(sa_x2));
    dec_dbl #(.DIG(OUT_DIG)) u_dbl_c1 (.d(ca),    .q(ca_x2));
    dec_dbl #(.DIG(OUT_DIG)) u_dbl_c2 (.d(ca_x2), .q(ca_x4));
    bin_csa32 #(.W(OUT_W)) u_csa_b (.x(v_o), .y(sa_x2), .z(ca_x4), .s(sb), .c(cb));
    dec_dbl #(.DIG(OUT_DIG)) u_dbl_h  (.d(cb),    .q(cb_x2));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_o     <= '0;
            dcar_o    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_o  <= sb;
                dcar_o <= cb_x2;
            end
        end
    end
endmodule

// File: rtl/dec_csa82_chk.sv
module dec_csa82_chk #(
    parameter  int DIGITS  = 4,
    localparam int IN_W    = 4 * DIGITS,
    localparam int OUT_W   = 4 * (DIGITS + 2)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [7:0][IN_W-1:0]  row_i,
    input logic                  out_valid,
    input logic [OUT_W-1:0]      sum_o,
    input logic [OUT_W-1:0]      dcar_o
);
    function automatic longint val_out(input logic [OUT_W-1:0] v);
        longint acc = 0;
        for (int i = DIGITS + 1; i >= 0; i--)
            acc = acc * 10 + 4 * v[4*i+3] + 2 * v[4*i+2] + 2 * v[4*i+1] + v[4*i];
        return acc;
    endfunction

    longint in_total;
    always_comb begin
        in_total = 0;
        for (int r = 0; r < 8; r++)
            in_total += val_out({{(OUT_W-IN_W){1'b0}}, row_i[r]});
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (!out_valid && sum_o == '0 && dcar_o == '0);
        end
    end

    assert_total_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (val_out(sum_o) + val_out(dcar_o)) == $past(in_total));

    assert_valid_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_idle_follows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_o) && $stable(dcar_o)));

    assert_even_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (dcar_o[0] == 1'b0));
endmodule

bind dec_csa82 dec_csa82_chk #(.DIGITS(DIGITS)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_i(row_i),
    .out_valid(out_valid), .sum_o(sum_o), .dcar_o(dcar_o)
);

// File: tb/sim_dec_csa82.sv
`timescale 1ns/1ps
module sim_dec_csa82;
    localparam int DIGITS = 4;
    localparam int IN_W   = 4 * DIGITS;
    localparam int OUT_W  = 4 * (DIGITS + 2);

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 in_valid;
    logic [7:0][IN_W-1:0] row_i;
    logic                 out_valid;
    logic [OUT_W-1:0]     sum_o, dcar_o;

    always #2 clk = ~clk;

    dec_csa82 #(.DIGITS(DIGITS)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .row_i(row_i),
        .out_valid(out_valid), .sum_o(sum_o), .dcar_o(dcar_o)
    );

    typedef struct {
        bit     v;
        bit     zero;
        longint tot;
        string  tag;
    } exp_t;

    exp_t q[$];
    int   n_chk = 0, n_fail = 0;
    bit   done = 0;

    function automatic longint dec_val(input logic [OUT_W-1:0] v);
        longint acc = 0;
        for (int i = DIGITS + 1; i >= 0; i--)
            acc = acc * 10 + 4 * v[4*i+3] + 2 * v[4*i+2] + 2 * v[4*i+1] + v[4*i];
        return acc;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic drive(input bit v, input logic [7:0][IN_W-1:0] rows, input string tag);
        exp_t e;
        longint t = 0;
        @(negedge clk);
        in_valid = v;
        row_i    = rows;
        for (int r = 0; r < 8; r++) t += dec_val({8'h00, rows[r]});
        e.v = v; e.tot = t; e.tag = tag; e.zero = (t == 0);
        q.push_back(e);
    endtask

    function automatic logic [7:0][IN_W-1:0] rnd_rows();
        logic [7:0][IN_W-1:0] x;
        for (int r = 0; r < 8; r++) x[r] = IN_W'($urandom);
        return x;
    endfunction

    // monitor: one entry per cycle, compared one clock after it was driven
    logic [OUT_W-1:0] prev_s = '0, prev_d = '0;
    always @(posedge clk) begin
        #1;
        if (rst_n && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            chk(out_valid == e.v, "R4 valid timing", longint'(out_valid), longint'(e.v));
            if (e.v) begin
                chk(dec_val(sum_o) + dec_val(dcar_o) == e.tot, e.tag,
                    dec_val(sum_o) + dec_val(dcar_o), e.tot);
                chk(dcar_o[0] == 1'b0, "R7 even carry", longint'(dcar_o[0]), 0);
                if (e.zero)
                    chk(sum_o == '0 && dcar_o == '0, "R9 zero rows",
                        longint'(sum_o | dcar_o), 0);
            end else begin
                chk(sum_o == prev_s && dcar_o == prev_d, "R5 hold on idle",
                    dec_val(sum_o) + dec_val(dcar_o), dec_val(prev_s) + dec_val(prev_d));
            end
            prev_s = sum_o;
            prev_d = dcar_o;
        end
    end

    initial begin
        #800000;
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", q.size(), 0);
        report();
    end

    initial begin
        logic [7:0][IN_W-1:0] rows;
        rst_n = 1'b0; in_valid = 1'b0; row_i = '0;
        repeat (3) @(negedge clk);
        chk(!out_valid && sum_o == '0 && dcar_o == '0, "R1 reset state",
            dec_val(sum_o) + dec_val(dcar_o), 0);
        rst_n = 1'b1;

        drive(1'b1, '0, "R3/R9 zeros");
        // R2: digit 0 of row 0 = 0110 (4), digit 1 of row 3 = 1001 (5): total 54
        rows = '0; rows[0][3:0] = 4'b0110; rows[3][7:4] = 4'b1001;
        drive(1'b1, rows, "R2 code weights");
        rows = '0; rows[5][3:0] = 4'b0100; rows[6][3:0] = 4'b0010;
        drive(1'b1, rows, "R2 middle bits");
        drive(1'b1, '1, "R6 all nines");
        drive(1'b0, rnd_rows(), "R5 idle");
        drive(1'b1, '1, "R6 all nines again");

        for (int k = 0; k < 200; k++) drive(1'b1, rnd_rows(), "R3/R8 back-to-back");
        for (int k = 0; k < 100; k++) begin
            drive(1'b1, rnd_rows(), "R3 sparse");
            drive(1'b0, rnd_rows(), "R5 idle");
            if (k % 3 == 0) drive(1'b0, rnd_rows(), "R5 idle");
        end
        drive(1'b0, '0, "R5 drain");
        while (q.size() > 0) @(negedge clk);
        report();
    end
endmodule